// File: doc/BRIEF.md
# AXI4-Lite Register Slave with Per-Register Access Control

This block puts a small fixed set of 32-bit control and status words on an AXI4-Lite bus and connects them to user logic. The map has four registers. A read-write control word sits at offset 0x00. A read-only status word is sampled from user logic at 0x04. A write-only command word sits at 0x08. A wide read-write word, 64 bits by default, occupies 0x0C upward. All offsets are taken relative to a base address parameter. Each accepted legal access raises a one-cycle strobe for the register it touched. This lets user logic react to a command write, or pop a status source on a read.

Every access gets a response code. An access that breaks a register's access mode, or that falls outside the map, is answered with SLVERR and leaves every register as it was. All legal accesses are answered with OKAY. Writes merge byte lanes under the write strobe.

A parameter enables a chain of synchronizer flip-flops. When it is on, the read-write register values reach user logic in the module clock domain, and the status input is brought into the bus clock domain before it is read.

Top module: `axil_regslave`

## Requirements
- R1: The write address and write data channels are accepted independently and in either order, or together. A register changes, and the write response becomes valid, only after both have been accepted. The response valid rises one cycle after the later of the two acceptances.
- R2: A write updates only the byte lanes whose write strobe bit is 1 (bit n covers data bits 8n+7..8n). The other lanes keep their old contents.
- R3: A write to the read-only status word at 0x04 returns SLVERR (2'b10) and changes nothing. A read of the write-only command word at 0x08 returns SLVERR with read data 0. Legal accesses return OKAY (2'b00). The command word value is driven on its output port.
- R4: The offset is the address minus the base address. Bits [1:0] of the offset are ignored. Any offset at or beyond the end of the map, including an address below the base, returns SLVERR with read data 0, and a write to such an offset changes nothing.
- R5: A legal write to a read-write or write-only register pulses that register's write strobe for exactly one cycle, in the cycle before the write response becomes valid. A legal read of a read-write or read-only register pulses its read strobe for exactly one cycle. Accesses that return SLVERR raise no strobe.
- R6: While reset is low and after it is released, the control word, the command word and the wide word hold their parameter defaults. The read data valid and write response valid outputs are low, and all three address/data ready outputs are high.
- R7: The wide register is split into consecutive 32-bit words starting at 0x0C, with the least significant word at the lowest offset. Each word is written and read on its own, and an access to any of its words pulses the wide register's strobes.
- R8: With synchronization enabled, the control and wide values reach their outputs through SYNC_STAGES module-clock flip-flops. The status input passes through SYNC_STAGES bus-clock flip-flops before it can be read, so a change is not visible to a read accepted one cycle later.
- R9: Write response valid and read data valid stay high, with stable response and data, until the matching ready is seen. No new address or data is accepted on that path while the response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Active-low asynchronous reset for both domains |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte-lane strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| mod_clk | input | 1 | User-logic clock for synchronized outputs |
| ctrl_q | output | 32 | Control word value (module domain) |
| ctrl_rd_stb | output | 1 | Control word read pulse |
| ctrl_wr_stb | output | 1 | Control word write pulse |
| stat_in | input | 32 | Status word from user logic |
| stat_rd_stb | output | 1 | Status word read pulse |
| cmd_q | output | 32 | Command word value (bus domain) |
| cmd_wr_stb | output | 1 | Command word write pulse |
| wide_q | output | WIDE_W | Wide register value (module domain) |
| wide_rd_stb | output | 1 | Wide register read pulse |
| wide_wr_stb | output | 1 | Wide register write pulse |

## Verification
A wrong capture flag in the write path shows within one cycle. Either bvalid rises before the second half of a write has arrived, or a write strobe fires twice, or it never completes, which the ordering tests catch at the response. A bad decode or access check appears on the very next response as a wrong code or nonzero error data, and a later read-back exposes a register that was corrupted. A missing or extra synchronizer stage appears at the outputs as a control value that shows up too early after the commit cycle, or as a status read that returns the new value one cycle after the input changed.

// File: rtl/axil_regslave_pkg.sv
`timescale 1ns/1ps
package axil_regslave_pkg;

   typedef enum logic [1:0] {
      ACC_RO   = 2'd0,
      ACC_WO   = 2'd1,
      ACC_RW   = 2'd2,
      ACC_NONE = 2'd3
   } acc_e;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   localparam int DATA_W = 32;
   localparam int STRB_W = DATA_W / 8;

   // owner codes of the four logical registers
   localparam logic [1:0] OWN_CTRL = 2'd0;
   localparam logic [1:0] OWN_STAT = 2'd1;
   localparam logic [1:0] OWN_CMD  = 2'd2;
   localparam logic [1:0] OWN_WIDE = 2'd3;

   // word 0 control, word 1 status, word 2 command, words 3.. wide
   function automatic acc_e map_mode(input int unsigned w);
      case (w)
         0:       return ACC_RW;
         1:       return ACC_RO;
         2:       return ACC_WO;
         default: return ACC_RW;
      endcase
   endfunction

   function automatic logic [1:0] map_owner(input int unsigned w);
      if (w < 3) return w[1:0];
      return OWN_WIDE;
   endfunction

   function automatic logic [DATA_W-1:0] lane_merge(
      input logic [DATA_W-1:0] old_v,
      input logic [DATA_W-1:0] new_v,
      input logic [STRB_W-1:0] strb);
      logic [DATA_W-1:0] r;
      r = old_v;
      for (int b = 0; b < STRB_W; b++) begin
         if (strb[b]) r[8*b +: 8] = new_v[8*b +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/axil_regslave_decode.sv
`timescale 1ns/1ps
module axil_regslave_decode #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter int                NUM_WORDS = 5,
   parameter int                IDX_W     = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   logic [ADDR_W-1:0] offs;
   logic [ADDR_W-1:0] word;

   assign offs = addr - BASE_ADDR;
   assign word = offs >> 2;
   assign hit  = (word < ADDR_W'(NUM_WORDS));
   assign idx  = word[IDX_W-1:0];
endmodule

// File: rtl/axil_regslave_wr.sv
`timescale 1ns/1ps
module axil_regslave_wr
   import axil_regslave_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              aclk,
   input  logic              aresetn,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic              cmt_err,
   output logic              cmt,
   output logic [ADDR_W-1:0] cmt_addr,
   output logic [DATA_W-1:0] cmt_data,
   output logic [STRB_W-1:0] cmt_strb
);
   logic aw_full, w_full;

   assign awready = !aw_full && !bvalid;
   assign wready  = !w_full && !bvalid;
   assign cmt     = aw_full && w_full;

   always_ff @(posedge aclk or negedge aresetn) begin
      if (!aresetn) begin
         aw_full  <= 1'b0;
         w_full   <= 1'b0;
         cmt_addr <= '0;
         cmt_data <= '0;
         cmt_strb <= '0;
         bvalid   <= 1'b0;
         bresp    <= RESP_OKAY;
      end else begin
         if (awvalid && awready) begin
            aw_full  <= 1'b1;
            cmt_addr <= awaddr;
         end
         if (wvalid && wready) begin
            w_full   <= 1'b1;
            cmt_data <= wdata;
            cmt_strb <= wstrb;
         end
         if (cmt) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            bvalid  <= 1'b1;
            bresp   <= cmt_err ? RESP_SLVERR : RESP_OKAY;
         end else if (bvalid && bready) begin
            bvalid <= 1'b0;
         end
      end
   end

   assert_b_hold_R9: assert property (@(posedge aclk) disable iff (!aresetn)
      bvalid && !bready |=> bvalid && $stable(bresp));

   assert_cmt_resp_R1: assert property (@(posedge aclk) disable iff (!aresetn)
      cmt |=> bvalid && !cmt);

   assert_aw_once_R1: assert property (@(posedge aclk) disable iff (!aresetn)
      awvalid && awready |=> !awready);
endmodule

// File: rtl/axil_regslave_rd.sv
`timescale 1ns/1ps
module axil_regslave_rd
   import axil_regslave_pkg::*;
(
   input  logic              aclk,
   input  logic              aresetn,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   output logic              ar_fire
);
   assign arready = !rvalid;
   assign ar_fire = arvalid && arready;

   always_ff @(posedge aclk or negedge aresetn) begin
      if (!aresetn) begin
         rvalid <= 1'b0;
         rdata  <= '0;
         rresp  <= RESP_OKAY;
      end else if (ar_fire) begin
         rvalid <= 1'b1;
         rdata  <= rd_err ? '0 : rd_data;
         rresp  <= rd_err ? RESP_SLVERR : RESP_OKAY;
      end else if (rvalid && rready) begin
         rvalid <= 1'b0;
      end
   end

   assert_r_hold_R9: assert property (@(posedge aclk) disable iff (!aresetn)
      rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp));

   assert_err_zero_R4: assert property (@(posedge aclk) disable iff (!aresetn)
      ar_fire && rd_err |=> rresp == RESP_SLVERR && rdata == '0);
endmodule

// File: rtl/axil_regslave_sync.sv
`timescale 1ns/1ps
module axil_regslave_sync #(
   parameter int           W       = 32,
   parameter int           STAGES  = 2,
   parameter bit           EN      = 1'b1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (EN) begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
            end else begin
               stage_q[0] <= d;
               for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end else begin : g_bypass
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/axil_regslave.sv
`timescale 1ns/1ps
module axil_regslave
   import axil_regslave_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = '0,
   parameter int                WIDE_W      = 64,
   parameter bit                SYNC_EN     = 1'b1,
   parameter int                SYNC_STAGES = 2,
   parameter logic [31:0]       CTRL_INIT   = 32'h0000_00A5,
   parameter logic [31:0]       CMD_INIT    = 32'h0000_0F0F,
   parameter logic [WIDE_W-1:0] WIDE_INIT   = '0
) (
   input  logic              aclk,
   input  logic              aresetn,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [31:0]       wdata,
   input  logic [3:0]        wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [31:0]       rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic              mod_clk,
   output logic [31:0]       ctrl_q,
   output logic              ctrl_rd_stb,
   output logic              ctrl_wr_stb,
   input  logic [31:0]       stat_in,
   output logic              stat_rd_stb,
   output logic [31:0]       cmd_q,
   output logic              cmd_wr_stb,
   output logic [WIDE_W-1:0] wide_q,
   output logic              wide_rd_stb,
   output logic              wide_wr_stb
);
   localparam int WIDE_WORDS = WIDE_W / DATA_W;
   localparam int NUM_WORDS  = 3 + WIDE_WORDS;
   localparam int IDX_W      = $clog2(NUM_WORDS);

   initial begin
      elab_wide_R7: assert (WIDE_W >= DATA_W && WIDE_W % DATA_W == 0)
         else $error("WIDE_W must be a positive multiple of 32");
      elab_sync_R8: assert (!SYNC_EN || SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
      elab_base_R4: assert (BASE_ADDR[1:0] == 2'b00)
         else $error("BASE_ADDR must be word aligned");
   end

   function automatic logic [DATA_W-1:0] word_init(input int unsigned w);
      if (w == 0) return CTRL_INIT;
      if (w == 2) return CMD_INIT;
      if (w >= 3) return WIDE_INIT[(w-3)*DATA_W +: DATA_W];
      return '0;
   endfunction

   // ---------------- write path
   logic              cmt, cmt_err;
   logic [ADDR_W-1:0] cmt_addr;
   logic [DATA_W-1:0] cmt_data;
   logic [STRB_W-1:0] cmt_strb;
   logic              wr_hit;
   logic [IDX_W-1:0]  wr_idx;
   logic              wr_ok;
   logic [1:0]        wr_own;

   axil_regslave_wr #(.ADDR_W(ADDR_W)) u_wr (
      .aclk     (aclk),
      .aresetn  (aresetn),
      .awaddr   (awaddr),
      .awvalid  (awvalid),
      .awready  (awready),
      .wdata    (wdata),
      .wstrb    (wstrb),
      .wvalid   (wvalid),
      .wready   (wready),
      .bresp    (bresp),
      .bvalid   (bvalid),
      .bready   (bready),
      .cmt_err  (cmt_err),
      .cmt      (cmt),
      .cmt_addr (cmt_addr),
      .cmt_data (cmt_data),
      .cmt_strb (cmt_strb)
   );

   axil_regslave_decode #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
      .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
   ) u_wr_dec (
      .addr (cmt_addr),
      .hit  (wr_hit),
      .idx  (wr_idx)
   );

   assign cmt_err = !wr_hit || (map_mode(int'(wr_idx)) == ACC_RO);
   assign wr_ok   = cmt && !cmt_err;
   assign wr_own  = map_owner(int'(wr_idx));

   // ---------------- storage
   logic [NUM_WORDS-1:0][DATA_W-1:0] store_q;

   always_ff @(posedge aclk or negedge aresetn) begin
      if (!aresetn) begin
         for (int i = 0; i < NUM_WORDS; i++) store_q[i] <= word_init(i);
      end else if (wr_ok) begin
         store_q[wr_idx] <= lane_merge(store_q[wr_idx], cmt_data, cmt_strb);
      end
   end

   // ---------------- read path
   logic              ar_fire;
   logic              rd_hit, rd_err;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] stat_b;
   logic              rd_ok;
   logic [1:0]        rd_own;

   axil_regslave_decode #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
      .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
   ) u_rd_dec (
      .addr (araddr),
      .hit  (rd_hit),
      .idx  (rd_idx)
   );

   always_comb begin
      rd_err  = 1'b1;
      rd_data = '0;
      if (rd_hit) begin
         case (map_mode(int'(rd_idx)))
            ACC_RO: begin
               rd_err  = 1'b0;
               rd_data = stat_b;
            end
            ACC_RW: begin
               rd_err  = 1'b0;
               rd_data = store_q[rd_idx];
            end
            default: begin
               rd_err  = 1'b1;
               rd_data = '0;
            end
         endcase
      end
   end

   axil_regslave_rd u_rd (
      .aclk    (aclk),
      .aresetn (aresetn),
      .arvalid (arvalid),
      .arready (arready),
      .rdata   (rdata),
      .rresp   (rresp),
      .rvalid  (rvalid),
      .rready  (rready),
      .rd_data (rd_data),
      .rd_err  (rd_err),
      .ar_fire (ar_fire)
   );

   assign rd_ok  = ar_fire && !rd_err;
   assign rd_own = map_owner(int'(rd_idx));

   // ---------------- strobes
   assign ctrl_wr_stb = wr_ok && (wr_own == OWN_CTRL);
   assign cmd_wr_stb  = wr_ok && (wr_own == OWN_CMD);
   assign wide_wr_stb = wr_ok && (wr_own == OWN_WIDE);
   assign ctrl_rd_stb = rd_ok && (rd_own == OWN_CTRL);
   assign stat_rd_stb = rd_ok && (rd_own == OWN_STAT);
   assign wide_rd_stb = rd_ok && (rd_own == OWN_WIDE);

   // ---------------- clock domain crossing
   logic [WIDE_W-1:0] wide_b;

   generate
      for (genvar j = 0; j < WIDE_WORDS; j++) begin : g_wide_cat
         assign wide_b[j*DATA_W +: DATA_W] = store_q[3+j];
      end
   endgenerate

   assign cmd_q = store_q[2];

   axil_regslave_sync #(
      .W(DATA_W), .STAGES(SYNC_STAGES), .EN(SYNC_EN), .RST_VAL(CTRL_INIT)
   ) u_sync_ctrl (
      .clk (mod_clk), .rst_n (aresetn), .d (store_q[0]), .q (ctrl_q)
   );

   axil_regslave_sync #(
      .W(WIDE_W), .STAGES(SYNC_STAGES), .EN(SYNC_EN), .RST_VAL(WIDE_INIT)
   ) u_sync_wide (
      .clk (mod_clk), .rst_n (aresetn), .d (wide_b), .q (wide_q)
   );

   axil_regslave_sync #(
      .W(DATA_W), .STAGES(SYNC_STAGES), .EN(SYNC_EN), .RST_VAL('0)
   ) u_sync_stat (
      .clk (aclk), .rst_n (aresetn), .d (stat_in), .q (stat_b)
   );

   // ---------------- checks
   assert_wr_onehot_R5: assert property (@(posedge aclk) disable iff (!aresetn)
      $onehot0({ctrl_wr_stb, cmd_wr_stb, wide_wr_stb}));

   assert_ctrl_wr_pulse_R5: assert property (@(posedge aclk) disable iff (!aresetn)
      ctrl_wr_stb |=> !ctrl_wr_stb);

   assert_wide_wr_pulse_R7: assert property (@(posedge aclk) disable iff (!aresetn)
      wide_wr_stb |=> !wide_wr_stb);

   assert_wr_err_resp_R3: assert property (@(posedge aclk) disable iff (!aresetn)
      cmt && cmt_err |=> bvalid && bresp == RESP_SLVERR);

   assert_wo_read_R3: assert property (@(posedge aclk) disable iff (!aresetn)
      ar_fire && rd_hit && map_mode(int'(rd_idx)) == ACC_WO
      |=> rresp == RESP_SLVERR && rdata == '0);

   assert_ro_hold_R3: assert property (@(posedge aclk) disable iff (!aresetn)
      $stable(store_q[1]));
endmodule

// File: tb/sim_axil_regslave.sv
`timescale 1ns/1ps
module sim_axil_regslave;
   localparam logic [31:0] B         = 32'h4000_0000;
   localparam logic [63:0] WIDE_INIT = 64'h1111_2222_3333_4444;
   localparam logic [31:0] STAT0     = 32'h5A5A_0001;
   localparam logic [1:0]  OK        = 2'b00;
   localparam logic [1:0]  ERR       = 2'b10;

   logic        aclk = 1'b0, mod_clk = 1'b0, aresetn = 1'b0;
   logic [31:0] awaddr = '0, wdata = '0, araddr = '0, stat_in = STAT0;
   logic [3:0]  wstrb = '0;
   logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
   logic        awready, wready, bvalid, arready, rvalid;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata, ctrl_q, cmd_q;
   logic [63:0] wide_q;
   logic        ctrl_rd_stb, ctrl_wr_stb, stat_rd_stb, cmd_wr_stb;
   logic        wide_rd_stb, wide_wr_stb;

   always #5 aclk = ~aclk;
   always #9 mod_clk = ~mod_clk;

   axil_regslave #(
      .ADDR_W(32), .BASE_ADDR(B), .WIDE_W(64), .SYNC_EN(1'b1),
      .SYNC_STAGES(2), .CTRL_INIT(32'h0000_00A5), .CMD_INIT(32'h0000_0F0F),
      .WIDE_INIT(WIDE_INIT)
   ) u0 (
      .aclk(aclk), .aresetn(aresetn),
      .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
      .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .araddr(araddr), .arvalid(arvalid), .arready(arready),
      .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
      .mod_clk(mod_clk), .ctrl_q(ctrl_q), .ctrl_rd_stb(ctrl_rd_stb),
      .ctrl_wr_stb(ctrl_wr_stb), .stat_in(stat_in), .stat_rd_stb(stat_rd_stb),
      .cmd_q(cmd_q), .cmd_wr_stb(cmd_wr_stb), .wide_q(wide_q),
      .wide_rd_stb(wide_rd_stb), .wide_wr_stb(wide_wr_stb)
   );

   int n_chk = 0, n_fail = 0;
   int c_ctrl_wr = 0, c_ctrl_rd = 0, c_stat_rd = 0, c_cmd_wr = 0;
   int c_wide_wr = 0, c_wide_rd = 0;

   always @(negedge aclk) begin
      c_ctrl_wr += int'(ctrl_wr_stb);
      c_ctrl_rd += int'(ctrl_rd_stb);
      c_stat_rd += int'(stat_rd_stb);
      c_cmd_wr  += int'(cmd_wr_stb);
      c_wide_wr += int'(wide_wr_stb);
      c_wide_rd += int'(wide_rd_stb);
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input bit do_aw, input bit do_w, input logic [31:0] a,
                       input logic [31:0] d, input logic [3:0] s);
      bit aw_pend, w_pend, a_ok, w_ok;
      @(negedge aclk);
      aw_pend = do_aw;
      w_pend  = do_w;
      if (do_aw) begin awaddr = a; awvalid = 1; end
      if (do_w) begin wdata = d; wstrb = s; wvalid = 1; end
      while (aw_pend || w_pend) begin
         a_ok = awvalid && awready;
         w_ok = wvalid && wready;
         @(posedge aclk);
         @(negedge aclk);
         if (a_ok) begin aw_pend = 0; awvalid = 0; end
         if (w_ok) begin w_pend = 0; wvalid = 0; end
      end
   endtask

   task automatic wait_b(output logic [1:0] resp);
      while (!bvalid) @(negedge aclk);
      resp = bresp;
      @(posedge aclk);
      @(negedge aclk);
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] s, output logic [1:0] resp);
      send(1, 1, a, d, s);
      wait_b(resp);
   endtask

   task automatic send_ar(input logic [31:0] a);
      bit ok;
      @(negedge aclk);
      araddr = a;
      arvalid = 1;
      forever begin
         ok = arready;
         @(posedge aclk);
         @(negedge aclk);
         if (ok) break;
      end
      arvalid = 0;
   endtask

   task automatic do_read(input logic [31:0] a, output logic [31:0] d,
                          output logic [1:0] resp);
      send_ar(a);
      while (!rvalid) @(negedge aclk);
      d = rdata;
      resp = rresp;
      @(posedge aclk);
      @(negedge aclk);
   endtask

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] data;
      logic [3:0]  strb;
      logic [31:0] exp;
      logic [1:0]  resp;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b0, B+32'h00, 32'h0,         4'h0, 32'h0000_00A5, OK},  // R6 default
      '{1'b0, B+32'h0C, 32'h0,         4'h0, 32'h3333_4444, OK},  // R6 R7 low word
      '{1'b0, B+32'h10, 32'h0,         4'h0, 32'h1111_2222, OK},  // R7 high word
      '{1'b1, B+32'h00, 32'hDEAD_BEEF, 4'hF, 32'h0,         OK},  // R2 full
      '{1'b0, B+32'h00, 32'h0,         4'h0, 32'hDEAD_BEEF, OK},
      '{1'b1, B+32'h00, 32'h1122_3344, 4'h5, 32'h0,         OK},  // R2 lanes 0,2
      '{1'b0, B+32'h00, 32'h0,         4'h0, 32'hDE22_BE44, OK},  // R2
      '{1'b1, B+32'h04, 32'hFFFF_FFFF, 4'hF, 32'h0,         ERR}, // R3 RO write
      '{1'b0, B+32'h04, 32'h0,         4'h0, STAT0,         OK},  // R3 RO read
      '{1'b0, B+32'h08, 32'h0,         4'h0, 32'h0,         ERR}, // R3 WO read
      '{1'b1, B+32'h08, 32'hCAFE_F00D, 4'hF, 32'h0,         OK},  // R3 WO write
      '{1'b0, B+32'h14, 32'h0,         4'h0, 32'h0,         ERR}, // R4 past end
      '{1'b1, B+32'h20, 32'h1234_5678, 4'hF, 32'h0,         ERR}, // R4 unmapped
      '{1'b0, B+32'h03, 32'h0,         4'h0, 32'hDE22_BE44, OK},  // R4 low bits
      '{1'b1, B+32'h0E, 32'hAAAA_5555, 4'hF, 32'h0,         OK},  // R7 low word
      '{1'b0, B+32'h0C, 32'h0,         4'h0, 32'hAAAA_5555, OK},  // R7
      '{1'b0, B+32'h10, 32'h0,         4'h0, 32'h1111_2222, OK},  // R7 untouched
      '{1'b0, B-32'h04, 32'h0,         4'h0, 32'h0,         ERR}, // R4 below base
      '{1'b1, B+32'h11, 32'h9999_0000, 4'hC, 32'h0,         OK},  // R2 R7
      '{1'b0, B+32'h10, 32'h0,         4'h0, 32'h9999_2222, OK}   // R2 R7
   };

   initial begin
      repeat (100000) @(posedge aclk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [1:0]  resp;
      logic [31:0] d;
      int          s0, s1, s2, s3, s4, s5;

      repeat (5) @(negedge aclk);
      // R6 reset state
      chk("R6 ready outs", {61'b0, awready, wready, arready}, 64'h7);
      chk("R6 valid outs", {62'b0, bvalid, rvalid}, 64'h0);
      chk("R6 ctrl_q in reset", ctrl_q, 64'h0000_00A5);
      aresetn = 1'b1;
      repeat (3) @(negedge aclk);
      chk("R6 ctrl_q", ctrl_q, 64'h0000_00A5);
      chk("R6 cmd_q", cmd_q, 64'h0000_0F0F);
      chk("R6 wide_q", wide_q, WIDE_INIT);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) begin
            do_write(VEC[i].addr, VEC[i].data, VEC[i].strb, resp);
            chk($sformatf("vec %0d bresp", i), 64'(resp), 64'(VEC[i].resp));
         end else begin
            do_read(VEC[i].addr, d, resp);
            chk($sformatf("vec %0d rresp", i), 64'(resp), 64'(VEC[i].resp));
            chk($sformatf("vec %0d rdata", i), 64'(d), 64'(VEC[i].exp));
         end
      end
      chk("R3 cmd_q drives write-only value", cmd_q, 64'hCAFE_F00D);
      repeat (6) @(negedge aclk);
      chk("R7 R8 wide_q word order", wide_q, 64'h9999_2222_AAAA_5555);
      chk("R8 ctrl_q synchronized", ctrl_q, 64'hDE22_BE44);

      // R5 strobes
      s0 = c_ctrl_wr; s1 = c_ctrl_rd;
      do_write(B, 32'h0000_0003, 4'hF, resp);
      chk("R5 ctrl write strobe count", 64'(c_ctrl_wr - s0), 64'd1);
      chk("R5 ctrl read strobe on write", 64'(c_ctrl_rd - s1), 64'd0);
      s1 = c_ctrl_rd;
      do_read(B, d, resp);
      chk("R5 ctrl read strobe count", 64'(c_ctrl_rd - s1), 64'd1);
      s0 = c_ctrl_wr; s2 = c_stat_rd; s3 = c_cmd_wr; s4 = c_wide_wr;
      do_write(B + 32'h04, 32'h1, 4'hF, resp);
      chk("R5 no strobe on RO write",
          64'((c_ctrl_wr - s0) + (c_stat_rd - s2) + (c_cmd_wr - s3) + (c_wide_wr - s4)), 64'd0);
      s2 = c_stat_rd;
      do_read(B + 32'h04, d, resp);
      chk("R5 stat read strobe count", 64'(c_stat_rd - s2), 64'd1);
      s1 = c_ctrl_rd; s2 = c_stat_rd; s5 = c_wide_rd;
      do_read(B + 32'h08, d, resp);
      chk("R5 no strobe on WO read",
          64'((c_ctrl_rd - s1) + (c_stat_rd - s2) + (c_wide_rd - s5)), 64'd0);
      s3 = c_cmd_wr;
      do_write(B + 32'h08, 32'h55, 4'hF, resp);
      chk("R5 cmd write strobe count", 64'(c_cmd_wr - s3), 64'd1);
      s4 = c_wide_wr;
      do_write(B + 32'h10, 32'h66, 4'h1, resp);
      chk("R7 wide write strobe on upper word", 64'(c_wide_wr - s4), 64'd1);
      s5 = c_wide_rd;
      do_read(B + 32'h0C, d, resp);
      chk("R7 wide read strobe on lower word", 64'(c_wide_rd - s5), 64'd1);
      s0 = c_ctrl_wr; s3 = c_cmd_wr; s4 = c_wide_wr;
      do_write(B + 32'h40, 32'h1, 4'hF, resp);
      chk("R4 no strobe on unmapped write",
          64'((c_ctrl_wr - s0) + (c_cmd_wr - s3) + (c_wide_wr - s4)), 64'd0);

      // R1 address before data
      send(1, 0, B + 32'h08, 32'h0, 4'h0);
      repeat (3) begin
         @(negedge aclk);
         chk("R1 no response before data", {62'b0, bvalid, cmd_wr_stb}, 64'h0);
      end
      chk("R1 cmd unchanged before data", cmd_q, 64'h0000_0055);
      send(0, 1, 32'h0, 32'h0000_0001, 4'hF);
      wait_b(resp);
      chk("R1 aw-first resp", 64'(resp), 64'(OK));
      chk("R1 aw-first value", cmd_q, 64'h0000_0001);
      // R1 data before address
      send(0, 1, 32'h0, 32'h0000_0002, 4'hF);
      repeat (3) begin
         @(negedge aclk);
         chk("R1 no response before address", {63'b0, bvalid}, 64'h0);
      end
      send(1, 0, B + 32'h08, 32'h0, 4'h0);
      wait_b(resp);
      chk("R1 w-first value", cmd_q, 64'h0000_0002);

      // R8 module-domain crossing of control word
      send(1, 1, B, 32'h0F0F_1234, 4'hF);
      chk("R5 strobe in commit cycle", {63'b0, ctrl_wr_stb}, 64'h1);
      @(negedge aclk);
      chk("R1 bvalid after commit", {63'b0, bvalid}, 64'h1);
      chk("R8 ctrl_q not yet updated", ctrl_q, 64'h0000_0003);
      wait_b(resp);
      repeat (6) @(negedge aclk);
      chk("R8 ctrl_q updated", ctrl_q, 64'h0F0F_1234);

      // R8 status crossing into bus domain
      @(negedge aclk);
      stat_in = 32'h0BAD_F00D;
      do_read(B + 32'h04, d, resp);
      chk("R8 status read one cycle after change", d, STAT0);
      repeat (4) @(negedge aclk);
      do_read(B + 32'h04, d, resp);
      chk("R8 status read after settling", d, 64'h0BAD_F00D);

      // R9 write response hold
      bready = 0;
      send(1, 1, B + 32'h08, 32'h77, 4'hF);
      repeat (3) begin
         @(negedge aclk);
         chk("R9 bvalid held, no accept", {61'b0, bvalid, awready, wready}, 64'h4);
      end
      bready = 1;
      wait_b(resp);
      chk("R9 bvalid released", {63'b0, bvalid}, 64'h0);
      // R9 read data hold
      rready = 0;
      send_ar(B);
      repeat (3) begin
         @(negedge aclk);
         chk("R9 rvalid held", {rvalid, arready, 30'b0, rdata}, {1'b1, 1'b0, 30'b0, 32'h0F0F_1234});
      end
      rready = 1;
      @(posedge aclk);
      @(negedge aclk);
      chk("R9 rvalid released", {63'b0, rvalid}, 64'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule